// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block sits behind a 32-bit memory-mapped port and behaves like the command front end of a parallel NOR flash. Writes carry an 8-bit command in the low data byte. When the interpreter is idle, a write is a pure command and its address does not matter. The command either moves a small operation state machine or selects what later reads return: the stored array word, the status register, or the device-ID and query views. The ID and query views are formatted by a neighbouring block that watches the read-mode pin.

The block holds the storage array, which is organised as erase blocks, and one lock bit per erase block. It carries out single-word program, whole-block erase, block lock and block unlock, and each of these takes one cycle. A failed or refused operation never stalls the bus. Instead it raises sticky error bits in the status register, which stay set until an explicit clear command. The bookkeeping for the buffered-program sequence lives here, so the command stream stays in step with the separate buffer datapath. The buffered data itself never reaches the array through this block.

The request port uses valid/ready. `req_ready` is held high, so every valid request is taken in the cycle it is presented. Read responses have no back-pressure: one cycle after a read is accepted, `rsp_valid` pulses for exactly one cycle and `rsp_rdata` carries the result. A write produces no response.

Top module: `nor_cmd_engine`

## Requirements
- R1: After reset the interpreter is idle, the read mode is array (`mode_o` = 0), the status register reads 0x80, every array word is 0xFFFFFFFF and no block is locked.
- R2: `req_ready` is always 1. Each accepted read is followed, one cycle later, by a single-cycle `rsp_valid` pulse carrying its data.
- R3: Read data depends on the read mode at acceptance. Mode 0 (array) returns the word at byte address `req_addr` with the two low bits ignored. Mode 1 (status) returns {8'h00, SR, 8'h00, SR}. Modes 2 (ID) and 3 (query) return zero.
- R4: In idle, the address of a write is ignored. Command 0x70 selects status mode, 0x90 selects ID mode and 0x98 selects query mode, and none of them changes anything else. A lone 0xD0 changes nothing. Command 0xFF, and any code with no meaning in idle, selects array mode.
- R5: Status bit 7 always reads 1. Error bits 0x20, 0x10 and 0x02 are sticky and only command 0x50 given in idle returns the register to 0x80.
- R6: Command 0x40 or 0x10 selects status mode. The next write then stores its data at its word address, one byte lane for each set bit of `req_be`, and the interpreter returns to idle in status mode.
- R7: A program aimed at a locked block leaves the array unchanged and sets status bits 0x10 and 0x02.
- R8: Command 0x20 followed by 0xD0 sets every word of the addressed erase block to 0xFFFFFFFF and leaves the other blocks untouched. The block index is the byte address divided by BLK_BYTES, and BLK_BYTES is a power of two.
- R9: An erase confirmed on a locked block sets bits 0x10 and 0x02. An erase whose second write is not 0xD0 sets bits 0x20 and 0x10. In both cases nothing is erased and the read mode becomes status.
- R10: Command 0x60 leaves the read mode unchanged. Its next write then locks the addressed block if the value is 0x01 or unlocks it if the value is 0xD0, and either of these selects status mode. Any other value sets bits 0x20 and 0x10 and leaves the lock bit as it was. In every case the interpreter returns to idle.
- R11: Command 0xE8 selects status mode. The next write's low byte N sets a count of min(N+1, BUF_WORDS) data writes, and these are absorbed without touching the array or being decoded. The write after them ends the sequence: 0xD0 completes it without error, and any other value sets bit 0x10. Either way the interpreter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write/command, 0 = read |
| req_addr | input | ADDR_W | Byte address within the device |
| req_wdata | input | 32 | Write data; command in bits 7:0 |
| req_be | input | 4 | Byte-lane enables for word program |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| mode_o | output | 2 | Read mode: 0 array, 1 status, 2 ID, 3 query |

## Verification
The bench sweeps every 8-bit command code through the idle decoder. A decoder with a missing or extra case would leave the wrong read mode behind, or swallow the next write as an operation. Program, erase and lock are run against locked and unlocked blocks with full readback sweeps of the array. These sweeps catch an erase that spills into a neighbouring block, a refused operation that still alters data, and error bits that fail to stick or to clear. The buffered sequence is run with a count that exceeds the buffer limit, and its data words are chosen to look like commands. A missing cap or a decoded data word would leave the interpreter stuck and ignoring the next mode command.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  typedef enum logic [2:0] {
    ST_READY,
    ST_LOCK_SETUP,
    ST_WPROG,
    ST_BUF_SETUP,
    ST_BUF_DATA,
    ST_ERASE_SETUP
  } nor_state_e;

  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_QUERY  = 2'd3
  } rd_mode_e;

  localparam logic [7:0] CMD_LOCK      = 8'h01;
  localparam logic [7:0] CMD_PROG_ALT  = 8'h10;
  localparam logic [7:0] CMD_ERASE     = 8'h20;
  localparam logic [7:0] CMD_PROG      = 8'h40;
  localparam logic [7:0] CMD_CLR_SR    = 8'h50;
  localparam logic [7:0] CMD_LOCK_SET  = 8'h60;
  localparam logic [7:0] CMD_RD_SR     = 8'h70;
  localparam logic [7:0] CMD_RD_ID     = 8'h90;
  localparam logic [7:0] CMD_RD_QRY    = 8'h98;
  localparam logic [7:0] CMD_CONFIRM   = 8'hD0;
  localparam logic [7:0] CMD_BUF_SET   = 8'hE8;
  localparam logic [7:0] CMD_RD_ARRAY  = 8'hFF;

  localparam logic [7:0] SR_READY      = 8'h80;
  localparam logic [7:0] SR_ERASE_FAIL = 8'h20;
  localparam logic [7:0] SR_PROG_FAIL  = 8'h10;
  localparam logic [7:0] SR_PROTECT    = 8'h02;

endpackage

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
  import nor_cmd_pkg::*;
#(
  parameter int BUF_WORDS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] cmd,
  input  logic       blk_locked,
  output logic       do_prog,
  output logic       do_erase,
  output logic       do_lock,
  output logic       do_unlock,
  output rd_mode_e   mode,
  output logic [7:0] status,
  output nor_state_e state
);
  localparam int CW = $clog2(BUF_WORDS + 1);

  nor_state_e state_q, state_d;
  rd_mode_e   mode_q, mode_d;
  logic [7:0] sr_q, sr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [8:0] want;

  assign want = {1'b0, cmd} + 9'd1;

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    sr_d      = sr_q;
    cnt_d     = cnt_q;
    do_prog   = 1'b0;
    do_erase  = 1'b0;
    do_lock   = 1'b0;
    do_unlock = 1'b0;
    if (wr_en) begin
      case (state_q)
        ST_READY: begin
          case (cmd)
            CMD_RD_SR:  mode_d = RM_STATUS;
            CMD_RD_ID:  mode_d = RM_IDENT;
            CMD_RD_QRY: mode_d = RM_QUERY;
            CMD_CLR_SR: sr_d = SR_READY;
            CMD_PROG, CMD_PROG_ALT: begin
              state_d = ST_WPROG;
              mode_d  = RM_STATUS;
            end
            CMD_LOCK_SET: state_d = ST_LOCK_SETUP;
            CMD_ERASE: begin
              state_d = ST_ERASE_SETUP;
              mode_d  = RM_STATUS;
            end
            CMD_BUF_SET: begin
              state_d = ST_BUF_SETUP;
              mode_d  = RM_STATUS;
            end
            CMD_CONFIRM: ;
            default: mode_d = RM_ARRAY;
          endcase
        end
        ST_LOCK_SETUP: begin
          if (cmd == CMD_LOCK) begin
            do_lock = 1'b1;
            mode_d  = RM_STATUS;
          end else if (cmd == CMD_CONFIRM) begin
            do_unlock = 1'b1;
            mode_d    = RM_STATUS;
          end else begin
            sr_d = sr_q | SR_ERASE_FAIL | SR_PROG_FAIL;
          end
          state_d = ST_READY;
        end
        ST_WPROG: begin
          if (blk_locked) sr_d = sr_q | SR_PROG_FAIL | SR_PROTECT;
          else            do_prog = 1'b1;
          state_d = ST_READY;
          mode_d  = RM_STATUS;
        end
        ST_ERASE_SETUP: begin
          if (cmd != CMD_CONFIRM)  sr_d = sr_q | SR_ERASE_FAIL | SR_PROG_FAIL;
          else if (blk_locked)     sr_d = sr_q | SR_PROG_FAIL | SR_PROTECT;
          else                     do_erase = 1'b1;
          state_d = ST_READY;
          mode_d  = RM_STATUS;
        end
        ST_BUF_SETUP: begin
          cnt_d   = (want > 9'(BUF_WORDS)) ? CW'(BUF_WORDS) : CW'(want);
          state_d = ST_BUF_DATA;
          mode_d  = RM_STATUS;
        end
        ST_BUF_DATA: begin
          if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
          end else begin
            if (cmd == CMD_CONFIRM) mode_d = RM_STATUS;
            else                    sr_d = sr_q | SR_PROG_FAIL;
            state_d = ST_READY;
          end
        end
        default: state_d = ST_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_READY;
      mode_q  <= RM_ARRAY;
      sr_q    <= SR_READY;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      sr_q    <= sr_d;
      cnt_q   <= cnt_d;
    end
  end

  assign mode   = mode_q;
  assign status = sr_q;
  assign state  = state_q;

endmodule

// File: rtl/nor_lock_map.sv
module nor_lock_map #(
  parameter int NUM_BLKS = 4,
  localparam int BW = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [BW-1:0] blk,
  input  logic          set_lock,
  input  logic          clr_lock,
  output logic          locked
);
  logic [NUM_BLKS-1:0] bits_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        bits_q <= '0;
    else if (set_lock) bits_q[blk] <= 1'b1;
    else if (clr_lock) bits_q[blk] <= 1'b0;
  end

  assign locked = bits_q[blk];

endmodule

// File: rtl/nor_store.sv
module nor_store #(
  parameter int WORDS = 256,
  parameter int WPB   = 64,
  localparam int AW   = $clog2(WORDS),
  localparam int NB   = WORDS / WPB,
  localparam int BW   = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog,
  input  logic          erase,
  input  logic [AW-1:0] widx,
  input  logic [BW-1:0] blk,
  input  logic [3:0]    be,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [WORDS-1:0][31:0] words;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '1;
      end else if (erase && blk == BW'(w / WPB)) begin
        word_q <= '1;
      end else if (prog && widx == AW'(w)) begin
        for (int b = 0; b < 4; b++)
          if (be[b]) word_q[8*b +: 8] <= wdata[8*b +: 8];
      end
    end
    assign words[w] = word_q;
  end

  assign rdata = words[widx];

endmodule

// File: rtl/nor_cmd_engine.sv
module nor_cmd_engine
  import nor_cmd_pkg::*;
#(
  parameter int BLK_BYTES = 256,
  parameter int NUM_BLKS  = 4,
  parameter int BUF_WORDS = 32,
  localparam int ADDR_W   = $clog2(BLK_BYTES * NUM_BLKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [3:0]        req_be,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [1:0]        mode_o
);
  localparam int WORDS = (BLK_BYTES * NUM_BLKS) / 4;
  localparam int WPB   = BLK_BYTES / 4;
  localparam int BSH   = $clog2(BLK_BYTES);
  localparam int BW    = (NUM_BLKS > 1) ? $clog2(NUM_BLKS) : 1;

  logic          wr_en;
  logic [BW-1:0] blk_idx;
  logic          blk_locked;
  logic          do_prog, do_erase, do_lock, do_unlock;
  rd_mode_e      mode_w;
  logic [7:0]    status_w;
  nor_state_e    state_w;
  logic [31:0]   array_word;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid && req_write;
  assign blk_idx   = BW'(req_addr >> BSH);

  nor_cmd_fsm #(.BUF_WORDS(BUF_WORDS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cmd(req_wdata[7:0]),
    .blk_locked(blk_locked), .do_prog(do_prog), .do_erase(do_erase),
    .do_lock(do_lock), .do_unlock(do_unlock), .mode(mode_w),
    .status(status_w), .state(state_w)
  );

  nor_lock_map #(.NUM_BLKS(NUM_BLKS)) u_lock (
    .clk(clk), .rst_n(rst_n), .blk(blk_idx), .set_lock(do_lock),
    .clr_lock(do_unlock), .locked(blk_locked)
  );

  nor_store #(.WORDS(WORDS), .WPB(WPB)) u_store (
    .clk(clk), .rst_n(rst_n), .prog(do_prog), .erase(do_erase),
    .widx(req_addr[ADDR_W-1:2]), .blk(blk_idx), .be(req_be),
    .wdata(req_wdata), .rdata(array_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        case (mode_w)
          RM_ARRAY:  rsp_rdata <= array_word;
          RM_STATUS: rsp_rdata <= {8'h00, status_w, 8'h00, status_w};
          default:   rsp_rdata <= '0;
        endcase
      end
    end
  end

  assign mode_o = mode_w;

endmodule

// File: rtl/nor_cmd_checker.sv
module nor_cmd_checker
  import nor_cmd_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic [1:0]  mode_o,
  input logic [7:0]  status,
  input nor_state_e  state,
  input logic        do_prog,
  input logic        do_erase,
  input logic        do_lock,
  input logic        do_unlock
);

  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);

  assert_status_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(mode_o) == 2'd1) |->
      rsp_rdata == {8'h00, $past(status), 8'h00, $past(status)});

  assert_ready_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status[7] == 1'b1);

  assert_sticky_errors_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && state == ST_READY && req_wdata[7:0] == CMD_CLR_SR)
      |=> ((status & $past(status)) == $past(status)));

  assert_single_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({do_prog, do_erase, do_lock, do_unlock}));

  assert_prog_returns_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && state == ST_WPROG) |=>
      (mode_o == 2'd1 && state == ST_READY));

  assert_buffer_no_array_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUF_DATA || state == ST_BUF_SETUP) |-> (!do_prog && !do_erase));

endmodule

bind nor_cmd_engine nor_cmd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .mode_o(mode_o), .status(status_w), .state(state_w), .do_prog(do_prog),
  .do_erase(do_erase), .do_lock(do_lock), .do_unlock(do_unlock)
);

// File: tb/nor_cmd_engine_tb.sv
`timescale 1ns/1ps
module nor_cmd_engine_tb;
  localparam int NW = 256;
  localparam int WPB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic [1:0]  mode_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] mdl [NW];
  logic [7:0]  sr_m;
  logic [3:0]  lk;

  always #2 clk = ~clk;

  nor_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mode_o(mode_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d, input logic [3:0] be);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
    d = rsp_rdata;
    req_valid = 1'b0;
  endtask

  task automatic chk_status(input string tag);
    logic [31:0] d;
    wr(10'h3F0, 32'h70, 4'hF);
    rd(10'h004, d);
    chk(tag, d, {8'h00, sr_m, 8'h00, sr_m});
  endtask

  task automatic sweep(input string tag);
    logic [31:0] d;
    wr(10'h155, 32'hFF, 4'hF);
    for (int i = 0; i < NW; i++) begin
      rd(10'(i * 4 + (i % 4)), d);
      chk(tag, d, mdl[i]);
    end
  endtask

  task automatic prog(input int w, input logic [31:0] d, input logic [3:0] be);
    wr(10'(w * 13), 32'h40, 4'hF);
    wr(10'(w * 4), d, be);
    if (lk[w / WPB]) sr_m = sr_m | 8'h12;
    else for (int b = 0; b < 4; b++) if (be[b]) mdl[w][8*b +: 8] = d[8*b +: 8];
  endtask

  task automatic clear_sr();
    wr(10'h0AA, 32'h50, 4'hF);
    sr_m = 8'h80;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NW; i++) mdl[i] = 32'hFFFF_FFFF;
    sr_m = 8'h80; lk = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 mode", {30'd0, mode_o}, 32'd0);
    chk("R2 ready", {31'd0, req_ready}, 32'd1);
    sweep("R1 erased array");
    chk_status("R1 status");

    // R6 program every word, full lanes
    for (int i = 0; i < NW; i++) begin
      logic [7:0] x;
      x = 8'(i);
      prog(i, {x ^ 8'hA5, x, ~x, x + 8'd3}, 4'hF);
    end
    chk("R6 mode after program", {30'd0, mode_o}, 32'd1);
    sweep("R6 R3 program readback");

    // R6 partial lanes
    prog(5, 32'h1122_3344, 4'b0101);
    prog(77, 32'hCAFE_F00D, 4'b1000);
    sweep("R6 byte lanes");

    // R4 sweep of all idle command codes
    for (int c = 0; c < 256; c++) begin
      logic [7:0] cc;
      logic [1:0] em;
      cc = 8'(c);
      if (cc == 8'h10 || cc == 8'h20 || cc == 8'h40 || cc == 8'h60 || cc == 8'hE8) continue;
      wr(10'h3FC, 32'h70, 4'hF);
      wr(10'(c * 4), {24'hABCDEF, cc}, 4'hF);
      case (cc)
        8'h70, 8'h50, 8'hD0: em = 2'd1;
        8'h90: em = 2'd2;
        8'h98: em = 2'd3;
        default: em = 2'd0;
      endcase
      chk("R4 idle decode", {30'd0, mode_o}, {30'd0, em});
    end
    wr(10'h000, 32'h90, 4'hF);
    rd(10'h008, d);
    chk("R3 ident data", d, 32'd0);
    wr(10'h000, 32'h98, 4'hF);
    rd(10'h040, d);
    chk("R3 query data", d, 32'd0);
    sweep("R4 commands left array intact");

    // R10 lock, R7 refused program
    wr(10'h000, 32'h60, 4'hF);
    chk("R10 lock setup keeps mode", {30'd0, mode_o}, 32'd0);
    wr(10'h108, 32'h01, 4'hF); lk[1] = 1'b1;
    chk("R10 lock selects status", {30'd0, mode_o}, 32'd1);
    prog(70, 32'hDEAD_BEEF, 4'hF);
    chk_status("R7 locked program status");
    prog(3, 32'h0BAD_CAFE, 4'hF);
    chk_status("R5 sticky after good program");
    sweep("R7 locked data unchanged");
    clear_sr();
    chk_status("R5 clear");

    // R8 erase block 2
    wr(10'h000, 32'h20, 4'hF);
    wr(10'h234, 32'hD0, 4'hF);
    for (int i = 2 * WPB; i < 3 * WPB; i++) mdl[i] = 32'hFFFF_FFFF;
    chk_status("R8 erase status");
    sweep("R8 erase block 2 only");

    // R9 refused erases
    wr(10'h000, 32'h20, 4'hF);
    wr(10'h1F0, 32'hD0, 4'hF); sr_m = sr_m | 8'h12;
    chk_status("R9 locked erase");
    clear_sr();
    wr(10'h000, 32'h20, 4'hF);
    wr(10'h010, 32'h33, 4'hF); sr_m = sr_m | 8'h30;
    chk("R9 bad erase mode", {30'd0, mode_o}, 32'd1);
    chk_status("R9 bad confirm");
    sweep("R9 nothing erased");
    clear_sr();

    // R10 bad lock value keeps lock
    wr(10'h000, 32'h60, 4'hF);
    wr(10'h100, 32'h77, 4'hF); sr_m = sr_m | 8'h30;
    chk_status("R10 bad lock value");
    clear_sr();
    prog(80, 32'h1234_5678, 4'hF);
    chk_status("R10 still locked");
    clear_sr();
    wr(10'h000, 32'h60, 4'hF);
    wr(10'h1FC, 32'hD0, 4'hF); lk[1] = 1'b0;
    chk("R10 unlock selects status", {30'd0, mode_o}, 32'd1);
    prog(80, 32'h1234_5678, 4'hF);
    wr(10'h000, 32'h60, 4'hF);
    wr(10'h3C0, 32'h01, 4'hF); lk[3] = 1'b1;
    wr(10'h000, 32'h20, 4'hF);
    wr(10'h0F0, 32'hD0, 4'hF);
    for (int i = 0; i < WPB; i++) mdl[i] = 32'hFFFF_FFFF;
    chk_status("R8 erase block 0 with block 3 locked");
    sweep("R8 R10 after unlock and erase");

    // R11 buffered sequences
    wr(10'h000, 32'hE8, 4'hF);
    chk("R11 setup mode", {30'd0, mode_o}, 32'd1);
    wr(10'h040, 32'h02, 4'hF);
    wr(10'h040, 32'h50, 4'hF);
    wr(10'h044, 32'h20, 4'hF);
    wr(10'h048, 32'h90, 4'hF);
    wr(10'h040, 32'hD0, 4'hF);
    chk("R11 confirm mode", {30'd0, mode_o}, 32'd1);
    chk_status("R11 good sequence");
    wr(10'h000, 32'hE8, 4'hF);
    wr(10'h000, 32'h00, 4'hF);
    wr(10'h000, 32'h98, 4'hF);
    wr(10'h000, 32'h44, 4'hF); sr_m = sr_m | 8'h10;
    wr(10'h000, 32'h90, 4'hF);
    chk("R11 idle after bad end", {30'd0, mode_o}, 32'd2);
    chk_status("R11 bad end status");
    clear_sr();
    wr(10'h000, 32'hE8, 4'hF);
    wr(10'h000, 32'hFF, 4'hF);
    for (int i = 0; i < 32; i++) wr(10'(i * 4), 32'h60, 4'hF);
    wr(10'h000, 32'hD0, 4'hF);
    wr(10'h000, 32'h98, 4'hF);
    chk("R11 count capped", {30'd0, mode_o}, 32'd3);
    chk_status("R11 capped status");
    sweep("R11 array untouched");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule